// File: doc/BRIEF.md
# Monitor Register Sweep Reader

This block services the register read port of an on-chip monitor converter. The converter samples four internal quantities in a repeating sequence: die temperature, core supply, block-memory supply and auxiliary supply. It signals the end of each sequence with a single-cycle pulse. That end-of-sequence pulse is the only event the block reacts to. When it arrives, the block fetches the four result registers through a handshaked read port, one read at a time. Each read places an address, raises a one-cycle enable with write-enable low, and waits for the ready pulse that carries the data.

The converter leaves each result as a 12-bit code in the upper twelve bits of a 16-bit status word. The block keeps a working copy of each code while the sweep runs. Once all four reads are done, it updates the four outputs together and raises a single-cycle valid strobe. It then waits for the next end-of-sequence pulse. An end-of-sequence pulse that arrives while a sweep is running is remembered, and another sweep follows straight away. Converting codes to physical units, configuring the converter and moving the results off chip are left to the surrounding logic.

Top module: `mon_sweep_reader`

## Requirements
- R1: While no sweep is running, `rd_en_o` stays low. A sweep starts only on a cycle where `eos_i` is high; the per-channel conversion pulses of the converter never reach the block.
- R2: A sweep issues exactly four reads, in this order: temperature at `ADDR_TEMP` (default 0x00), core supply at `ADDR_VCORE` (default 0x01), block-memory supply at `ADDR_VBRAM` (default 0x06), auxiliary supply at `ADDR_VAUX` (default 0x02).
- R3: Every read is a one-cycle `rd_en_o` pulse with `rd_we_o` low. `rd_addr_o` holds its value from the enable cycle until `rd_rdy_i` returns. No new enable is issued while a read is outstanding.
- R4: On each `rd_rdy_i` the block keeps `rd_data_i[15:4]` for the channel being read. The four result outputs change only together, at the end of a sweep.
- R5: `res_valid_o` is high for exactly one cycle: the cycle after the clock edge that samples the fourth `rd_rdy_i` of a sweep. On that same cycle the new results appear.
- R6: If `eos_i` is high during a sweep, the block records it. The next sweep's first `rd_en_o` then comes in the cycle right after the fourth ready, and any number of such pulses within one sweep cause only one extra sweep.
- R7: If no end-of-sequence pulse was recorded, the block returns to idle after a sweep. It repeats the same four reads on every later end-of-sequence pulse, with no limit.
- R8: Holding `rst_n` low synchronously clears the results, `res_valid_o`, `rd_en_o` and any recorded pulse, and stops a sweep that is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read-port clock |
| rst_n | input | 1 | Synchronous reset, active low |
| eos_i | input | 1 | End-of-sequence pulse from the converter |
| rd_en_o | output | 1 | Read enable, one cycle per read |
| rd_we_o | output | 1 | Write enable, always low |
| rd_addr_o | output | AW (7) | Register address of the current read |
| rd_data_i | input | DW (16) | Read data, valid with `rd_rdy_i` |
| rd_rdy_i | input | 1 | Read ready, one cycle per completed read |
| temp_o | output | CODE_W (12) | Die temperature code |
| vcore_o | output | CODE_W (12) | Core supply code |
| vbram_o | output | CODE_W (12) | Block-memory supply code |
| vaux_o | output | CODE_W (12) | Auxiliary supply code |
| res_valid_o | output | 1 | One-cycle strobe when new results appear |

## Verification
The first pattern is a converter model that produces a conversion pulse every 100 cycles and an end-of-sequence pulse with every fourth one. This confirms that the block stays quiet between sequences and repeats clean sweeps in the right address order. The second pattern drives end-of-sequence pulses 5 to 22 cycles apart, with ready latencies of one to four cycles. These pulses land inside sweeps, sometimes several in one sweep and sometimes on the final ready. This tells a single pending flag apart from a dropped pulse or a counted queue. The returned words carry changing low nibbles and different values on every read, so a wrong bit slice, a swapped channel or a partial update shows up. A reset in the middle of a sweep, followed by a fresh periodic run, checks that the block restarts from a clean state.

// File: rtl/mon_sweep_pkg.sv
// Shared constants and types for the monitor sweep reader.
// Assumes exactly four monitored channels, read in index order 0..3.
package mon_sweep_pkg;

    localparam int MS_CH_NUM = 4;
    localparam int MS_CH_W   = $clog2(MS_CH_NUM);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } sweep_st_t;

endpackage

// File: rtl/mon_sweep_ctrl.sv
// Sweep sequencer: starts on an end-of-sequence pulse, steps through the
// channel indices one handshaked read at a time, and remembers one pulse
// that arrives mid-sweep.
// Assumes the read port answers each enable with exactly one ready pulse,
// no earlier than the cycle after the enable.
module mon_sweep_ctrl
    import mon_sweep_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               eos_i,
    input  logic               rdy_i,
    output logic               issue_o,
    output logic [MS_CH_W-1:0] ch_o,
    output logic               cap_o,
    output logic               commit_o
);

    localparam logic [MS_CH_W-1:0] LAST_CH = MS_CH_W'(MS_CH_NUM - 1);

    sweep_st_t          st_q, st_d;
    logic [MS_CH_W-1:0] ch_q;
    logic               pend_q;
    logic               want_sweep;
    logic               last_rdy;
    logic               go;

    // Decode start and completion conditions of the current cycle.
    always_comb begin
        want_sweep = eos_i | pend_q;
        cap_o      = (st_q == ST_WAIT) & rdy_i;
        last_rdy   = cap_o & (ch_q == LAST_CH);
        go         = ((st_q == ST_IDLE) & want_sweep) | (last_rdy & want_sweep);
    end

    // Next-state selection.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (go) st_d = ST_ISSUE;
            ST_ISSUE: st_d = ST_WAIT;
            ST_WAIT: begin
                if (rdy_i) begin
                    if (ch_q != LAST_CH) st_d = ST_ISSUE;
                    else if (go)         st_d = ST_ISSUE;
                    else                 st_d = ST_IDLE;
                end
            end
            default:  st_d = ST_IDLE;
        endcase
    end

    // State, channel index and pending flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            ch_q   <= '0;
            pend_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (go)
                ch_q <= '0;
            else if (cap_o && (ch_q != LAST_CH))
                ch_q <= ch_q + MS_CH_W'(1);
            if (go)
                pend_q <= 1'b0;
            else if (eos_i)
                pend_q <= 1'b1;
        end
    end

    assign issue_o  = (st_q == ST_ISSUE);
    assign ch_o     = ch_q;
    assign commit_o = last_rdy;

endmodule

// File: rtl/mon_sweep_addr.sv
// Channel-to-address map: selects the status register address of the
// channel being read from a packed parameter table (channel 0 in the LSBs).
// Assumes the channel index never exceeds the table size.
module mon_sweep_addr
    import mon_sweep_pkg::*;
#(
    parameter int                         AW       = 7,
    parameter logic [MS_CH_NUM*AW-1:0]    ADDR_TAB = '0
) (
    input  logic [MS_CH_W-1:0] ch_i,
    output logic [AW-1:0]      addr_o
);

    logic [AW-1:0] addr_arr [MS_CH_NUM];

    // Unpack one table slot per channel.
    for (genvar g = 0; g < MS_CH_NUM; g++) begin : g_slot
        assign addr_arr[g] = ADDR_TAB[g*AW +: AW];
    end

    // Present the address of the current channel.
    assign addr_o = addr_arr[ch_i];

endmodule

// File: rtl/mon_sweep_capture.sv
// Result capture: keeps the code field of each returned word in a working
// copy, then loads all published results at once on the last ready and
// pulses the valid strobe.
// Assumes commit_i is only high together with cap_i for the last channel.
module mon_sweep_capture
    import mon_sweep_pkg::*;
#(
    parameter int DW       = 16,
    parameter int CODE_W   = 12,
    parameter int CODE_LSB = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cap_i,
    input  logic                        commit_i,
    input  logic [MS_CH_W-1:0]          ch_i,
    input  logic [DW-1:0]               data_i,
    output logic [MS_CH_NUM*CODE_W-1:0] res_o,
    output logic                        valid_o
);

    logic [CODE_W-1:0] code;
    logic [CODE_W-1:0] work_q [MS_CH_NUM-1];

    assign code = data_i[CODE_LSB +: CODE_W];

    // Mark the data bits outside the code field as deliberately unused.
    if (CODE_LSB > 0) begin : g_low
        logic unused_low;
        assign unused_low = ^data_i[CODE_LSB-1:0];
    end
    if (CODE_LSB + CODE_W < DW) begin : g_high
        logic unused_high;
        assign unused_high = ^data_i[DW-1:CODE_LSB+CODE_W];
    end

    for (genvar g = 0; g < MS_CH_NUM; g++) begin : g_ch
        if (g < MS_CH_NUM - 1) begin : g_work
            // Working copy of one early channel.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    work_q[g] <= '0;
                else if (cap_i && (ch_i == MS_CH_W'(g)))
                    work_q[g] <= code;
            end
            // Published result of that channel, loaded at sweep end.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    res_o[g*CODE_W +: CODE_W] <= '0;
                else if (commit_i)
                    res_o[g*CODE_W +: CODE_W] <= work_q[g];
            end
        end else begin : g_last
            // Last channel is published straight from the returning word.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    res_o[g*CODE_W +: CODE_W] <= '0;
                else if (commit_i)
                    res_o[g*CODE_W +: CODE_W] <= code;
            end
        end
    end

    // One-cycle strobe after the result update.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_o <= 1'b0;
        else        valid_o <= commit_i;
    end

endmodule

// File: rtl/mon_sweep_reader.sv
// Monitor register sweep reader, top level.
// On each end-of-sequence pulse it reads the temperature, core, block-memory
// and auxiliary result registers in that order through a handshaked read
// port, then publishes the four codes with a one-cycle valid strobe.
// Assumes one ready pulse per enable, arriving at least one cycle later.
module mon_sweep_reader
    import mon_sweep_pkg::*;
#(
    parameter int            AW         = 7,
    parameter int            DW         = 16,
    parameter int            CODE_W     = 12,
    parameter int            CODE_LSB   = 4,
    parameter logic [AW-1:0] ADDR_TEMP  = 7'h00,
    parameter logic [AW-1:0] ADDR_VCORE = 7'h01,
    parameter logic [AW-1:0] ADDR_VBRAM = 7'h06,
    parameter logic [AW-1:0] ADDR_VAUX  = 7'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eos_i,
    output logic              rd_en_o,
    output logic              rd_we_o,
    output logic [AW-1:0]     rd_addr_o,
    input  logic [DW-1:0]     rd_data_i,
    input  logic              rd_rdy_i,
    output logic [CODE_W-1:0] temp_o,
    output logic [CODE_W-1:0] vcore_o,
    output logic [CODE_W-1:0] vbram_o,
    output logic [CODE_W-1:0] vaux_o,
    output logic              res_valid_o
);

    localparam logic [MS_CH_NUM*AW-1:0] ADDR_TAB =
        {ADDR_VAUX, ADDR_VBRAM, ADDR_VCORE, ADDR_TEMP};

    logic [MS_CH_W-1:0]          ch;
    logic                        cap;
    logic                        commit;
    logic [MS_CH_NUM*CODE_W-1:0] res;

    mon_sweep_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .eos_i    (eos_i),
        .rdy_i    (rd_rdy_i),
        .issue_o  (rd_en_o),
        .ch_o     (ch),
        .cap_o    (cap),
        .commit_o (commit)
    );

    mon_sweep_addr #(
        .AW       (AW),
        .ADDR_TAB (ADDR_TAB)
    ) u_addr (
        .ch_i   (ch),
        .addr_o (rd_addr_o)
    );

    mon_sweep_capture #(
        .DW       (DW),
        .CODE_W   (CODE_W),
        .CODE_LSB (CODE_LSB)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_i    (cap),
        .commit_i (commit),
        .ch_i     (ch),
        .data_i   (rd_data_i),
        .res_o    (res),
        .valid_o  (res_valid_o)
    );

    assign rd_we_o = 1'b0;
    assign temp_o  = res[0*CODE_W +: CODE_W];
    assign vcore_o = res[1*CODE_W +: CODE_W];
    assign vbram_o = res[2*CODE_W +: CODE_W];
    assign vaux_o  = res[3*CODE_W +: CODE_W];

endmodule

// File: rtl/mon_sweep_chk.sv
// Protocol checker for the sweep reader, observing only its ports.
// Tracks outstanding reads and ready count on its own.
module mon_sweep_chk
    import mon_sweep_pkg::*;
#(
    parameter int AW     = 7,
    parameter int CODE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic              rd_we,
    input logic              rd_rdy,
    input logic [AW-1:0]     rd_addr,
    input logic              res_valid,
    input logic [CODE_W-1:0] temp,
    input logic [CODE_W-1:0] vcore,
    input logic [CODE_W-1:0] vbram,
    input logic [CODE_W-1:0] vaux
);

    logic               outst_q;
    logic [MS_CH_W-1:0] rdy_cnt_q;

    // Outstanding-read flag and ready counter modulo the channel count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst_q   <= 1'b0;
            rdy_cnt_q <= '0;
        end else begin
            if (rd_en)       outst_q <= 1'b1;
            else if (rd_rdy) outst_q <= 1'b0;
            if (rd_rdy) rdy_cnt_q <= rdy_cnt_q + MS_CH_W'(1);
        end
    end

    p_en_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en);
    p_we_with_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !rd_we);
    p_one_outstanding_r3: assert property (@(posedge clk) disable iff (!rst_n)
        outst_q |-> !rd_en);
    p_addr_held_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> $stable(rd_addr));
    p_addr_held_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (outst_q && !rd_rdy) |=> $stable(rd_addr));
    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    p_valid_after_fourth_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (rdy_cnt_q == '0));
    p_hold_results_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> ($stable(temp) && $stable(vcore) && $stable(vbram) && $stable(vaux)));

endmodule

bind mon_sweep_reader mon_sweep_chk #(
    .AW     (AW),
    .CODE_W (CODE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en_o),
    .rd_we     (rd_we_o),
    .rd_rdy    (rd_rdy_i),
    .rd_addr   (rd_addr_o),
    .res_valid (res_valid_o),
    .temp      (temp_o),
    .vcore     (vcore_o),
    .vbram     (vbram_o),
    .vaux      (vaux_o)
);

// File: tb/test_mon_sweep_reader.sv
// Bench: converter and read-port models plus a behavioural reference model
// compared against the outputs on every clock.
module test_mon_sweep_reader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eos_r = 1'b0;
    logic        rdy_r = 1'b0;
    logic [15:0] data_r = '0;
    logic        rd_en, rd_we, valid;
    logic [6:0]  rd_addr;
    logic [11:0] temp, vcore, vbram, vaux;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int mode  = 0;   // 0 periodic converter, 1 dense pulses, 2 quiet
    bit done  = 0;

    always #5 clk = ~clk;

    mon_sweep_reader i_mon_sweep_reader (
        .clk(clk), .rst_n(rst_n), .eos_i(eos_r),
        .rd_en_o(rd_en), .rd_we_o(rd_we), .rd_addr_o(rd_addr),
        .rd_data_i(data_r), .rd_rdy_i(rdy_r),
        .temp_o(temp), .vcore_o(vcore), .vbram_o(vbram), .vaux_o(vaux),
        .res_valid_o(valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s cycle=%0d actual=0x%0h expected=0x%0h", req, cyc, act, exp);
        end
    endtask

    // Reference model state
    int m_addr[4] = '{0, 1, 6, 2};
    bit m_active = 0, m_issue = 0, m_pend = 0, m_valid = 0, m_from_pend = 0;
    int m_idx = 0;
    int m_buf[4];
    int m_res[4] = '{0, 0, 0, 0};
    int n_valid = 0, n_pend_starts = 0;

    // Reference model step at each rising edge, from bench-driven inputs only.
    always @(posedge clk) begin
        m_valid = 0;
        if (!rst_n) begin
            m_active = 0; m_issue = 0; m_pend = 0; m_idx = 0; m_from_pend = 0;
            for (int i = 0; i < 4; i++) m_res[i] = 0;
        end else if (!m_active) begin
            if (eos_r) begin
                m_active = 1; m_issue = 1; m_idx = 0; m_from_pend = 0;
            end
        end else if (m_issue) begin
            m_issue = 0;
            m_from_pend = 0;
            if (eos_r) m_pend = 1;
        end else if (rdy_r) begin
            m_buf[m_idx] = int'(data_r[15:4]);
            if (m_idx == 3) begin
                for (int i = 0; i < 4; i++) m_res[i] = m_buf[i];
                m_valid = 1;
                n_valid++;
                if (eos_r || m_pend) begin
                    m_from_pend = 1; n_pend_starts++;
                    m_issue = 1; m_idx = 0; m_pend = 0;
                end else begin
                    m_active = 0;
                end
            end else begin
                m_idx++;
                m_issue = 1;
                if (eos_r) m_pend = 1;
            end
        end else if (eos_r) begin
            m_pend = 1;
        end
    end

    // Read-port and converter models
    int lat_cnt = 0, salt = 0, eoc_ph = 0, eoc_n = 0, gap = 8;
    logic [15:0] lfsr = 16'hACE1;

    function automatic logic [15:0] reg_word(input logic [6:0] a, input int s);
        return 16'((int'(a) * 40503 + s * 2654435) ^ (s << 3) ^ 16'h5A3C);
    endfunction

    // Compare at the falling edge, then drive the next inputs.
    always @(negedge clk) begin
        cyc++;
        if (!done) begin
            chk(rd_en === m_issue, m_issue ? (m_from_pend ? "R6" : "R3") : "R1/R7",
                int'(rd_en), int'(m_issue));
            chk(rd_we === 1'b0, "R3", int'(rd_we), 0);
            if (m_active)
                chk(int'(rd_addr) == m_addr[m_idx], "R2", int'(rd_addr), m_addr[m_idx]);
            chk(valid === m_valid, "R5", int'(valid), int'(m_valid));
            chk(int'(temp)  == m_res[0], "R4 temp",  int'(temp),  m_res[0]);
            chk(int'(vcore) == m_res[1], "R4 vcore", int'(vcore), m_res[1]);
            chk(int'(vbram) == m_res[2], "R4 vbram", int'(vbram), m_res[2]);
            chk(int'(vaux)  == m_res[3], "R4 vaux",  int'(vaux),  m_res[3]);
        end
        lfsr  = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        eos_r = 1'b0;
        rdy_r = 1'b0;
        if (!rst_n) begin
            lat_cnt = 0;
        end else if (rd_en) begin
            lat_cnt = 1 + int'(lfsr[1:0]);
        end else if (lat_cnt > 0) begin
            lat_cnt--;
            if (lat_cnt == 0) begin
                rdy_r  = 1'b1;
                salt++;
                data_r = reg_word(rd_addr, salt);
            end
        end
        if (mode == 0) begin
            // conversion pulse every 100 cycles, sequence end every fourth
            eoc_ph++;
            if (eoc_ph == 100) begin
                eoc_ph = 0;
                eoc_n++;
                if (eoc_n % 4 == 0) eos_r = 1'b1;
            end
        end else if (mode == 1) begin
            gap--;
            if (gap == 0) begin
                eos_r = 1'b1;
                gap = 5 + int'(lfsr[7:3]) % 18;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(rd_en === 1'b0, "R8 rd_en", int'(rd_en), 0);
        chk(valid === 1'b0, "R8 valid", int'(valid), 0);
        chk({temp, vcore, vbram, vaux} === '0, "R8 results", int'(temp), 0);
        rst_n = 1'b1;
        mode = 0;
        repeat (4500) @(negedge clk);
        chk(n_valid >= 10, "R7 repeated sweeps", n_valid, 10);
        mode = 1;
        repeat (3000) @(negedge clk);
        chk(n_pend_starts > 0, "R6 pending sweeps seen", n_pend_starts, 1);
        // mid-sweep reset
        while (!m_active || m_idx != 2) @(negedge clk);
        rst_n = 1'b0;
        mode = 2;
        repeat (2) @(negedge clk);
        chk(rd_en === 1'b0, "R8 rd_en mid", int'(rd_en), 0);
        chk({temp, vcore, vbram, vaux} === '0, "R8 results mid", int'(vaux), 0);
        chk(valid === 1'b0, "R8 valid mid", int'(valid), 0);
        rst_n = 1'b1;
        repeat (50) @(negedge clk);
        chk(rd_en === 1'b0, "R8 R1 idle after reset", int'(rd_en), 0);
        eoc_ph = 0;
        mode = 0;
        repeat (1300) @(negedge clk);
        chk(n_valid >= 13, "R7 sweeps after reset", n_valid, 13);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule